// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 16 by 16 one-bit cursor picture over a monochrome raster stream. The raster side supplies, every clock, the current line and column and the background pixel at that position. The block then returns the final pixel one clock later. The cursor's horizontal position comes from a cursor-X register. Its vertical position is built from three character-cell timing fields: the cursor row address, the number of scan lines per character row, and a scan-start offset.

A control bit chooses how the cursor meets the background. In OR mode, set cursor bits force the pixel white. In AND mode, set cursor bits force it black. Clear cursor bits are transparent in both modes. Bit 5 of the scan-start field hides the cursor entirely. Cursor columns at or past the screen width are never drawn. A small write port loads the picture one 16-bit row at a time.

The datapath is a single registered stage with no sequencing: the hit test, the picture lookup and the combine all settle inside one clock.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high, `pix_out` is 0 on the following clock and every picture row is cleared to all zeros. Reset takes priority over a write issued in the same cycle.
- R2: A write with `wr_en` high stores `wr_data` as picture row `wr_row` (row 0 is the top row) at the clock edge. Lookups use the new row from the next clock onward. Bit 0 of a row word is the leftmost pixel, that is, the one at column X.
- R3: The cursor top line Y equals `cell_row` × (`cell_scans` + 1) + `scan_start`, using all 8 bits of each field and computed without truncation.
- R4: The cursor left column X equals the low 10 bits of `curx_reg`. Bits 15:10 have no effect.
- R5: When `scan_start` bit 5 is 1, the cursor is hidden and `pix_out` equals the background.
- R6: With `fn_or` = 1, a covered pixel becomes background OR cursor bit.
- R7: With `fn_or` = 0, a covered pixel becomes background AND NOT cursor bit.
- R8: A pixel is covered only when Y ≤ line < Y+16 and X ≤ column < X+16. In that case the cursor bit is row (line−Y), bit (column−X). Any other pixel passes the background through unchanged.
- R9: A column at or beyond `SCREEN_W` is never covered, even inside the X window.
- R10: `pix_out` is valid exactly one clock after its inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Picture row write strobe |
| wr_row | input | 4 | Picture row index for a write |
| wr_data | input | 16 | Picture row contents, bit 0 leftmost |
| ras_line | input | LINE_W | Current raster line |
| ras_col | input | COL_W | Current raster column |
| bg_pix | input | 1 | Background pixel at that position |
| curx_reg | input | XREG_W | Cursor-X register; the low XSEL_W bits are used |
| cell_row | input | CRTC_W | Cursor row address in character cells |
| cell_scans | input | CRTC_W | Scan lines per character row, minus one |
| scan_start | input | CRTC_W | Cursor scan-start offset; bit 5 hides the cursor |
| fn_or | input | 1 | Combine select: 1 = OR (white), 0 = AND NOT (black) |
| pix_out | output | 1 | Final pixel, one clock after its inputs |

## Verification
The bench builds the block with `SCREEN_W` = 800 while keeping a 10-bit cursor X and a 10-bit column. Cursor positions from 785 up to 1023 are therefore legal register values, so the right-edge clipping and the columns past the screen can both be reached directly. The small 8-bit cell fields keep Y inside the 10-bit line range for the chosen settings, so the window's top and bottom edges can be swept line by line. Both combine modes are exercised against white and black background. Hidden-cursor cases and writes issued in the same cycle as a lookup are also covered.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
    localparam int CUR_N    = 16;
    localparam int CUR_IDXW = $clog2(CUR_N);
    localparam int HIDE_BIT = 5;
    typedef logic [CUR_N-1:0] cur_row_t;
endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap
    import cursor_overlay_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CUR_IDXW-1:0] wr_row,
    input  cur_row_t            wr_data,
    input  logic [CUR_IDXW-1:0] rd_row,
    input  logic [CUR_IDXW-1:0] rd_col,
    output logic                rd_bit
);
    cur_row_t rows [CUR_N];

    for (genvar r = 0; r < CUR_N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                rows[r] <= '0;
            else if (wr_en && (wr_row == CUR_IDXW'(r)))
                rows[r] <= wr_data;
        end
    end

    cur_row_t sel_row;
    always_comb begin
        sel_row = rows[rd_row];
        rd_bit  = sel_row[rd_col];
    end
endmodule

// File: rtl/cursor_ypos.sv
module cursor_ypos
    import cursor_overlay_pkg::*;
#(
    parameter int CRTC_W = 8,
    localparam int YW    = 2*CRTC_W + 2
)(
    input  logic [CRTC_W-1:0] cell_row,
    input  logic [CRTC_W-1:0] cell_scans,
    input  logic [CRTC_W-1:0] scan_start,
    output logic [YW-1:0]     top_y,
    output logic              visible
);
    logic [CRTC_W:0] rows_per_cell;
    always_comb begin
        rows_per_cell = {1'b0, cell_scans} + 1'b1;
        top_y = YW'(cell_row) * YW'(rows_per_cell) + YW'(scan_start);
        visible = ~scan_start[HIDE_BIT];
    end
endmodule

// File: rtl/cursor_window.sv
module cursor_window
    import cursor_overlay_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int COL_W    = 10,
    parameter int XSEL_W   = 10,
    parameter int YW       = 18,
    parameter int SCREEN_W = 1024,
    localparam int LW      = ((YW > LINE_W) ? YW : LINE_W) + 1,
    localparam int CW      = ((XSEL_W > COL_W) ? XSEL_W : COL_W) + 1
)(
    input  logic [LINE_W-1:0]   ras_line,
    input  logic [COL_W-1:0]    ras_col,
    input  logic [YW-1:0]       top_y,
    input  logic [XSEL_W-1:0]   left_x,
    output logic                in_win,
    output logic [CUR_IDXW-1:0] row_idx,
    output logic [CUR_IDXW-1:0] col_idx
);
    logic [LW-1:0] line_e, y_e, dy;
    logic [CW-1:0] col_e, x_e, dx;
    logic          rows_ok, cols_ok, on_screen;

    always_comb begin
        line_e = LW'(ras_line);
        y_e    = LW'(top_y);
        col_e  = CW'(ras_col);
        x_e    = CW'(left_x);
        dy     = line_e - y_e;
        dx     = col_e - x_e;
        rows_ok   = (line_e >= y_e) && (dy[LW-1:CUR_IDXW] == '0);
        cols_ok   = (col_e  >= x_e) && (dx[CW-1:CUR_IDXW] == '0);
        on_screen = (32'(ras_col) < 32'(SCREEN_W));
        in_win    = rows_ok && cols_ok && on_screen;
        row_idx   = dy[CUR_IDXW-1:0];
        col_idx   = dx[CUR_IDXW-1:0];
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_overlay_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int COL_W    = 10,
    parameter int XREG_W   = 16,
    parameter int XSEL_W   = 10,
    parameter int CRTC_W   = 8,
    parameter int SCREEN_W = 1024
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CUR_IDXW-1:0] wr_row,
    input  logic [CUR_N-1:0]    wr_data,
    input  logic [LINE_W-1:0]   ras_line,
    input  logic [COL_W-1:0]    ras_col,
    input  logic                bg_pix,
    input  logic [XREG_W-1:0]   curx_reg,
    input  logic [CRTC_W-1:0]   cell_row,
    input  logic [CRTC_W-1:0]   cell_scans,
    input  logic [CRTC_W-1:0]   scan_start,
    input  logic                fn_or,
    output logic                pix_out
);
    localparam int YW = 2*CRTC_W + 2;

    logic [YW-1:0]       top_y;
    logic                visible;
    logic [XSEL_W-1:0]   left_x;
    logic                in_win;
    logic                hit;
    logic [CUR_IDXW-1:0] row_idx, col_idx;
    logic                pic_bit;
    logic                cur_bit;
    logic                pix_nxt;
    logic                unused_xhi;

    assign left_x     = curx_reg[XSEL_W-1:0];
    assign unused_xhi = ^curx_reg[XREG_W-1:XSEL_W];

    cursor_ypos #(.CRTC_W(CRTC_W)) u_ypos (
        .cell_row   (cell_row),
        .cell_scans (cell_scans),
        .scan_start (scan_start),
        .top_y      (top_y),
        .visible    (visible)
    );

    cursor_window #(
        .LINE_W(LINE_W), .COL_W(COL_W), .XSEL_W(XSEL_W),
        .YW(YW), .SCREEN_W(SCREEN_W)
    ) u_win (
        .ras_line (ras_line),
        .ras_col  (ras_col),
        .top_y    (top_y),
        .left_x   (left_x),
        .in_win   (in_win),
        .row_idx  (row_idx),
        .col_idx  (col_idx)
    );

    cursor_bitmap u_bmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  (row_idx),
        .rd_col  (col_idx),
        .rd_bit  (pic_bit)
    );

    always_comb begin
        hit     = visible && in_win;
        cur_bit = hit && pic_bit;
        if (fn_or)
            pix_nxt = bg_pix | cur_bit;
        else
            pix_nxt = bg_pix & ~cur_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= 1'b0;
        else     pix_out <= pix_nxt;
    end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int COL_W    = 10,
    parameter int CRTC_W   = 8,
    parameter int SCREEN_W = 1024
)(
    input logic              clk,
    input logic              rst,
    input logic [COL_W-1:0]  ras_col,
    input logic              bg_pix,
    input logic [CRTC_W-1:0] scan_start,
    input logic              fn_or,
    input logic              hit,
    input logic              pix_out
);
    AST_HIDDEN_PASS: assert property (@(posedge clk) disable iff (rst)
        scan_start[5] |=> (pix_out == $past(bg_pix)));                        // R5
    AST_OR_KEEPS_WHITE: assert property (@(posedge clk) disable iff (rst)
        (fn_or && bg_pix) |=> pix_out);                                       // R6
    AST_AND_KEEPS_BLACK: assert property (@(posedge clk) disable iff (rst)
        (!fn_or && !bg_pix) |=> !pix_out);                                    // R7
    AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (pix_out == $past(bg_pix)));                                 // R8
    AST_CLIP_PASS: assert property (@(posedge clk) disable iff (rst)
        (32'(ras_col) >= 32'(SCREEN_W)) |=> (pix_out == $past(bg_pix)));     // R9
endmodule

bind cursor_overlay cursor_overlay_chk #(
    .COL_W(COL_W), .CRTC_W(CRTC_W), .SCREEN_W(SCREEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_col    (ras_col),
    .bg_pix     (bg_pix),
    .scan_start (scan_start),
    .fn_or      (fn_or),
    .hit        (hit),
    .pix_out    (pix_out)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
    localparam int SW = 800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_row = '0;
    logic [15:0] wr_data = '0;
    logic [9:0]  ras_line = '0;
    logic [9:0]  ras_col = '0;
    logic        bg_pix = 1'b0;
    logic [15:0] curx_reg = '0;
    logic [7:0]  cell_row = '0;
    logic [7:0]  cell_scans = '0;
    logic [7:0]  scan_start = '0;
    logic        fn_or = 1'b0;
    logic        pix_out;

    int vectors = 0;
    int misses  = 0;
    logic [15:0] bm [16];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    cursor_overlay #(.SCREEN_W(SW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .ras_line(ras_line), .ras_col(ras_col), .bg_pix(bg_pix),
        .curx_reg(curx_reg), .cell_row(cell_row), .cell_scans(cell_scans),
        .scan_start(scan_start), .fn_or(fn_or), .pix_out(pix_out)
    );

    function automatic logic ref_pix();
        int y, x, ln, cl;
        logic b;
        if (rst) return 1'b0;
        y  = int'(cell_row) * (int'(cell_scans) + 1) + int'(scan_start);
        x  = int'(curx_reg) % 1024;
        ln = int'(ras_line);
        cl = int'(ras_col);
        if (scan_start[5]) return bg_pix;
        if (ln < y || ln >= y + 16 || cl < x || cl >= x + 16 || cl >= SW) return bg_pix;
        b = bm[ln - y][cl - x];
        return fn_or ? (bg_pix | b) : (bg_pix & ~b);
    endfunction

    task automatic cycle(input string tag);
        logic exp;
        exp = ref_pix();
        @(posedge clk);
        #1;
        vectors++;
        if (pix_out !== exp) begin
            misses++;
            $display("FAIL %s: line=%0d col=%0d pix_out=%b expected=%b",
                     tag, ras_line, ras_col, pix_out, exp);
        end
        if (rst) begin
            for (int i = 0; i < 16; i++) bm[i] = '0;
        end else if (wr_en) begin
            bm[wr_row] = wr_data;
        end
        wr_en = 1'b0;
    endtask

    task automatic set_cur(input int cr, input int cs, input int ss, input int xr);
        cell_row   = 8'(cr);
        cell_scans = 8'(cs);
        scan_start = 8'(ss);
        curx_reg   = 16'(xr);
    endtask

    task automatic sweep(input string tag, input int y0, input int x0, input logic bg);
        for (int l = y0 - 2; l < y0 + 18; l++) begin
            for (int c = x0 - 2; c < x0 + 18; c++) begin
                ras_line = 10'(l);
                ras_col  = 10'(c);
                bg_pix   = bg;
                cycle(tag);
            end
        end
    endtask

    task automatic load_rows(input logic [15:0] seed);
        for (int r = 0; r < 16; r++) begin
            wr_en   = 1'b1;
            wr_row  = 4'(r);
            wr_data = seed ^ 16'(r * 16'h1357) ^ 16'(16'h0001 << r);
            cycle("R2");
        end
    endtask

    initial begin
        #1;
        for (int i = 0; i < 16; i++) bm[i] = 16'hFFFF;
        fn_or = 1'b1;
        set_cur(2, 7, 3, 40);
        // R1: output held low during reset, write blocked by reset
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; wr_row = 4'(i); wr_data = 16'hFFFF;
            bg_pix = 1'b1;
            cycle("R1");
        end
        rst = 1'b0;
        // R1: picture cleared, OR over black stays black
        sweep("R1", 19, 40, 1'b0);
        // R2: rows loaded, bit 0 leftmost
        load_rows(16'hA5C3);
        wr_en = 1'b1; wr_row = 4'd3; wr_data = 16'h0001;
        ras_line = 10'd22; ras_col = 10'd40; bg_pix = 1'b0;
        cycle("R2");
        ras_col = 10'd40; cycle("R2");
        ras_col = 10'd55; cycle("R2");
        // R2: write and lookup in the same cycle see the old row
        wr_en = 1'b1; wr_row = 4'd3; wr_data = 16'h8000;
        ras_col = 10'd55; cycle("R2");
        cycle("R2");
        sweep("R6", 19, 40, 1'b0);
        // R3: several cell geometries
        set_cur(5, 15, 6, 100);   sweep("R3", 86, 100, 1'b0);
        set_cur(0, 0, 0, 0);      sweep("R3", 0, 0, 1'b0);
        set_cur(30, 29, 17, 300); sweep("R3", 917, 300, 1'b0);
        set_cur(3, 255, 0, 500);  sweep("R3", 768, 500, 1'b0);
        // R4: upper bits of cursor-X ignored
        set_cur(1, 9, 4, 16'hFC00 | 200); sweep("R4", 14, 200, 1'b0);
        // R5: hidden cursor
        set_cur(1, 9, 4 | 32, 200); sweep("R5", 46, 200, 1'b0);
        fn_or = 1'b0;               sweep("R5", 46, 200, 1'b1);
        // R7: AND mode over white and black
        set_cur(4, 11, 2, 640);
        load_rows(16'h3C96);
        sweep("R7", 50, 640, 1'b1);
        sweep("R7", 50, 640, 1'b0);
        // R6: OR over white
        fn_or = 1'b1; sweep("R6", 50, 640, 1'b1);
        // R9: right-edge clipping
        set_cur(2, 9, 0, 792); sweep("R9", 20, 792, 1'b0);
        fn_or = 1'b0; sweep("R9", 20, 792, 1'b1);
        set_cur(2, 9, 0, 1016); sweep("R9", 20, 1016, 1'b1);
        // R8 / R10: pseudo-random traffic
        for (int n = 0; n < 6000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (n % 400 == 0)
                set_cur(int'(lfsr[3:0]), int'(lfsr[7:4]), int'(lfsr[13:8]),
                        int'(lfsr[25:16]));
            if (lfsr[31:28] == 4'h0) begin
                wr_en = 1'b1; wr_row = lfsr[11:8]; wr_data = lfsr[27:12];
            end
            fn_or    = lfsr[14];
            bg_pix   = lfsr[15];
            ras_line = 10'(int'(cell_row) * (int'(cell_scans) + 1)
                           + int'(scan_start) + int'(lfsr[20:16]) - 8);
            ras_col  = 10'(int'(curx_reg[9:0]) + int'(lfsr[27:22]) - 24);
            cycle((n % 2 == 0) ? "R8" : "R10");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #1_000_000;
        misses++;
        $display("FAIL watchdog: run hung, pix_out=%b expected=done", pix_out);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule